// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller with Mailboxes

This block collects level-sensitive device interrupt lines and a set of inter-processor mailbox bits, and drives one interrupt line per CPU. Each CPU owns its own enable words and its own masked source view, so the same device or mailbox bit can be steered to any subset of CPUs. Software reaches the block through a simple 32-bit register port with separate read and write strobes. A read returns its data one cycle later.

The raw state and each CPU's enable state can be reached through three aliases: plain, set-ones and clear-ones. The alias groups are spaced by a stride that is derived from the number of device lines. Every group holds two words. The first word carries the device bits and the second word carries the mailbox bits. Mailbox bits are packed two per CPU. A CPU raises an inter-processor interrupt by setting another CPU's mailbox bit. The target CPU reads its source word, handles the lowest set bit, and then acknowledges that bit through the clear-ones alias.

Top module: `ipi_irq_ctrl`

## Requirements
- R1: After reset, every enable word and every mailbox raw bit is zero, `irq_o` is all zero, and `rvalid_o` is low.
- R2: Byte offset 0 is read-only and returns `NUM_DEV` (4 by default). Writes to offset 0 have no effect.
- R3: The group stride is `S = 8*(1+(NUM_DEV-1)/64)` bytes, which is 8 by default. Group k sits at `8 + k*S`, with k = 0 raw, 1 raw-set, 2 raw-clear, 3 source, 4 enable, 5 enable-set, 6 enable-clear. Within a group, the device word is at +0 and the mailbox word is at +4. Groups 3 to 6 are repeated for CPU c at an extra `c*4*S` bytes; the raw groups exist once. With the defaults, CPU1's enable word is at 72 and 76. Any unmapped address reads as 0.
- R4: Device raw bit i always equals input line `dev_irq_i[i]`. It is not latched. A write to any raw device word is ignored.
- R5: The mailbox bit for mailbox m of CPU c is at index `2*c+m`. Writing ones to the raw-set mailbox word (byte 20) raises those bits. Writing ones to the raw-clear mailbox word (byte 28) acknowledges them. Zero bits in the written value leave the state unchanged.
- R6: Writes to the plain raw group and to the source groups are ignored.
- R7: A write to the plain enable word loads the written value. A write to the enable-set word sets the bits that are one in the written value. A write to the enable-clear word clears the bits that are one. Zero bits leave the state unchanged.
- R8: A read of a set or clear alias returns the current value of the state behind it.
- R9: CPU c's source word equals the raw word AND CPU c's enable word, separately for the device word and the mailbox word.
- R10: `irq_o[c]` is high exactly while any bit of either of CPU c's source words is set. It follows changes on the device lines in the same cycle.
- R11: `rvalid_o` is high in the cycle after each read strobe, and `rdata_o` then holds the value addressed by that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| dev_irq_i | input | NUM_DEV | Level-sensitive device interrupt lines |
| addr_i | input | ADDR_W | Byte address of the access |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, registered |
| rvalid_o | output | 1 | Read data valid, one cycle after `rd_en_i` |
| irq_o | output | NUM_CPU | Per-CPU interrupt request line |

## Verification
The masking function is exercised with several device-line patterns (1010, then all low) against enable words that are loaded, set bit-wise and cleared bit-wise. A wrong AND, or an enable alias that overwrites the word instead of setting or clearing only the selected bits, gives a different source word. The mailbox path raises bits for both CPUs one after another, and then acknowledges only one of them. This separates a per-bit set or clear from a whole-word load, and it separates a correct CPU index from a wrong one, because only CPU1's line may rise. Writes to the plain raw group, to the device raw-set word, to the source group and to the identification register, together with reads of unmapped addresses, show that the decode touches nothing outside its own groups.

// File: rtl/ipi_irq_pkg.sv
// Package: shared types and layout helpers for the interrupt controller.
// Assumes device words fit in 32 bits (NUM_DEV <= 32).
package ipi_irq_pkg;
    // Order equals group index k in the address map.
    typedef enum logic [2:0] {
        GRP_RAW     = 3'd0,
        GRP_RAW_SET = 3'd1,
        GRP_RAW_CLR = 3'd2,
        GRP_SRC     = 3'd3,
        GRP_EN      = 3'd4,
        GRP_EN_SET  = 3'd5,
        GRP_EN_CLR  = 3'd6,
        GRP_NONE    = 3'd7
    } grp_e;

    localparam int unsigned GROUP_BASE   = 8;
    localparam int unsigned MB_PER_CPU   = 2;
    localparam int unsigned RAW_GROUPS   = 3;
    localparam int unsigned CPU_GROUPS   = 4;

    // Byte distance between consecutive groups.
    function automatic int unsigned grp_stride(int unsigned nbits);
        return 8 * (1 + (nbits - 1) / 64);
    endfunction
endpackage

// File: rtl/ipi_addr_dec.sv
// Address decoder: maps a byte address to a group, a CPU index and a word
// select (device word or mailbox word). Purely combinational.
// Assumes word-aligned accesses; misaligned or unmapped addresses give GRP_NONE.
module ipi_addr_dec
    import ipi_irq_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned NUM_CPU = 2,
    parameter int unsigned STRIDE  = 8,
    parameter int unsigned CPU_W   = 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output grp_e              grp_o,
    output logic              id_o,
    output logic [CPU_W-1:0]  cpu_o,
    output logic              mbw_o
);
    int unsigned a, off, g, w, c, k;

    // Split the address into group, CPU copy and word within the group.
    always_comb begin
        a     = 32'(addr_i);
        off   = 0;
        g     = 0;
        w     = 0;
        c     = 0;
        k     = 0;
        grp_o = GRP_NONE;
        id_o  = 1'b0;
        cpu_o = '0;
        mbw_o = 1'b0;
        if (a[1:0] == 2'b00) begin
            if (a == 0) begin
                id_o = 1'b1;
            end else if (a >= GROUP_BASE) begin
                off = a - GROUP_BASE;
                g   = off / STRIDE;
                w   = (off % STRIDE) / 4;
                if (w < 2) begin
                    mbw_o = (w == 1);
                    if (g < RAW_GROUPS) begin
                        grp_o = grp_e'(g[2:0]);
                    end else begin
                        c = (g - RAW_GROUPS) / CPU_GROUPS;
                        k = (g - RAW_GROUPS) % CPU_GROUPS;
                        if (c < NUM_CPU) begin
                            grp_o = grp_e'(3'(k + RAW_GROUPS));
                            cpu_o = CPU_W'(c);
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/ipi_mbox_raw.sv
// Mailbox raw state: one bit per mailbox, raised by set-ones writes and
// acknowledged by clear-ones writes. Assumes set and clear never coincide
// (single write port); set wins if they do.
module ipi_mbox_raw #(
    parameter int unsigned MB_W = 4
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            set_i,
    input  logic            clr_i,
    input  logic [MB_W-1:0] mask_i,
    output logic [MB_W-1:0] raw_o
);
    // Update raw mailbox bits from masked set/clear writes.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)     raw_o <= '0;
        else if (set_i)  raw_o <= raw_o | mask_i;
        else if (clr_i)  raw_o <= raw_o & ~mask_i;
    end

    // R5: selected bits rise after a set-ones write
    a_r5_raise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i |=> ((raw_o & $past(mask_i)) == $past(mask_i)));
    // R5: selected bits fall after a clear-ones write
    a_r5_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && !set_i) |=> ((raw_o & $past(mask_i)) == '0));
    // R5: unselected bits keep their value
    a_r5_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_i || clr_i) |=> ((raw_o & ~$past(mask_i)) == ($past(raw_o) & ~$past(mask_i))));
endmodule

// File: rtl/ipi_cpu_bank.sv
// Per-CPU bank: device and mailbox enable words with load/set/clear access,
// the masked source words and the CPU's interrupt line.
// Assumes at most one of the three write strobes is high in a cycle.
module ipi_cpu_bank #(
    parameter int unsigned DEV_W = 4,
    parameter int unsigned MB_W  = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_load_i,
    input  logic             wr_set_i,
    input  logic             wr_clr_i,
    input  logic             mbw_i,
    input  logic [DEV_W-1:0] wdev_i,
    input  logic [MB_W-1:0]  wmb_i,
    input  logic [DEV_W-1:0] dev_raw_i,
    input  logic [MB_W-1:0]  mb_raw_i,
    output logic [DEV_W-1:0] en_dev_o,
    output logic [MB_W-1:0]  en_mb_o,
    output logic [DEV_W-1:0] src_dev_o,
    output logic [MB_W-1:0]  src_mb_o,
    output logic             irq_o
);
    // Device enable word: load, set-ones or clear-ones.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                  en_dev_o <= '0;
        else if (!mbw_i && wr_load_i) en_dev_o <= wdev_i;
        else if (!mbw_i && wr_set_i)  en_dev_o <= en_dev_o | wdev_i;
        else if (!mbw_i && wr_clr_i)  en_dev_o <= en_dev_o & ~wdev_i;
    end

    // Mailbox enable word: load, set-ones or clear-ones.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                 en_mb_o <= '0;
        else if (mbw_i && wr_load_i) en_mb_o <= wmb_i;
        else if (mbw_i && wr_set_i)  en_mb_o <= en_mb_o | wmb_i;
        else if (mbw_i && wr_clr_i)  en_mb_o <= en_mb_o & ~wmb_i;
    end

    // Masked source words and the CPU interrupt line.
    assign src_dev_o = dev_raw_i & en_dev_o;
    assign src_mb_o  = mb_raw_i & en_mb_o;
    assign irq_o     = (|src_dev_o) | (|src_mb_o);

    // R7: set-ones write sets the selected device enables
    a_r7_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_set_i && !mbw_i) |=> ((en_dev_o & $past(wdev_i)) == $past(wdev_i)));
    // R7: clear-ones write clears the selected device enables
    a_r7_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_clr_i && !mbw_i) |=> ((en_dev_o & $past(wdev_i)) == '0));
    // R7: a device-word write leaves the mailbox enables alone
    a_r7_other_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mbw_i |=> $stable(en_mb_o));
    // R10: with nothing enabled the line stays low
    a_r10_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((en_dev_o == '0) && (en_mb_o == '0)) |-> !irq_o);
endmodule

// File: rtl/ipi_irq_ctrl.sv
// Top: multiprocessor interrupt controller with mailboxes. Decodes the
// register port, holds the mailbox raw state, one bank per CPU, and a
// registered read path. Assumes rd_en_i and wr_en_i are never high together.
module ipi_irq_ctrl
    import ipi_irq_pkg::*;
#(
    parameter int unsigned NUM_CPU = 2,
    parameter int unsigned NUM_DEV = 4,
    parameter int unsigned ADDR_W  = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_DEV-1:0] dev_irq_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               wr_en_i,
    input  logic [31:0]        wdata_i,
    input  logic               rd_en_i,
    output logic [31:0]        rdata_o,
    output logic               rvalid_o,
    output logic [NUM_CPU-1:0] irq_o
);
    localparam int unsigned STRIDE = grp_stride(NUM_DEV);
    localparam int unsigned MB_W   = NUM_CPU * MB_PER_CPU;
    localparam int unsigned CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;
    localparam int unsigned MAX_W  = (NUM_DEV > MB_W) ? NUM_DEV : MB_W;

    grp_e              grp;
    logic              is_id;
    logic [CPU_W-1:0]  cpu_sel;
    logic              mbw;
    logic [MB_W-1:0]   mb_raw;
    logic [NUM_CPU-1:0][NUM_DEV-1:0] en_dev, src_dev;
    logic [NUM_CPU-1:0][MB_W-1:0]    en_mb, src_mb;
    logic [31:0]       rd_word;

    ipi_addr_dec #(
        .ADDR_W(ADDR_W), .NUM_CPU(NUM_CPU), .STRIDE(STRIDE), .CPU_W(CPU_W)
    ) u_dec (
        .addr_i(addr_i), .grp_o(grp), .id_o(is_id), .cpu_o(cpu_sel), .mbw_o(mbw)
    );

    ipi_mbox_raw #(.MB_W(MB_W)) u_mbox (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (wr_en_i && grp == GRP_RAW_SET && mbw),
        .clr_i  (wr_en_i && grp == GRP_RAW_CLR && mbw),
        .mask_i (wdata_i[MB_W-1:0]),
        .raw_o  (mb_raw)
    );

    // One enable/source bank per CPU.
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        logic hit;
        assign hit = wr_en_i && (cpu_sel == CPU_W'(c));
        ipi_cpu_bank #(.DEV_W(NUM_DEV), .MB_W(MB_W)) u_bank (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .wr_load_i (hit && grp == GRP_EN),
            .wr_set_i  (hit && grp == GRP_EN_SET),
            .wr_clr_i  (hit && grp == GRP_EN_CLR),
            .mbw_i     (mbw),
            .wdev_i    (wdata_i[NUM_DEV-1:0]),
            .wmb_i     (wdata_i[MB_W-1:0]),
            .dev_raw_i (dev_irq_i),
            .mb_raw_i  (mb_raw),
            .en_dev_o  (en_dev[c]),
            .en_mb_o   (en_mb[c]),
            .src_dev_o (src_dev[c]),
            .src_mb_o  (src_mb[c]),
            .irq_o     (irq_o[c])
        );
    end

    if (MAX_W < 32) begin : g_unused
        logic unused_wdata_hi;
        assign unused_wdata_hi = ^wdata_i[31:MAX_W];
    end

    // Select the addressed word for a read.
    always_comb begin
        rd_word = '0;
        if (is_id) begin
            rd_word = 32'(NUM_DEV);
        end else begin
            unique case (grp)
                GRP_RAW, GRP_RAW_SET, GRP_RAW_CLR:
                    rd_word = mbw ? 32'(mb_raw) : 32'(dev_irq_i);
                GRP_SRC:
                    rd_word = mbw ? 32'(src_mb[cpu_sel]) : 32'(src_dev[cpu_sel]);
                GRP_EN, GRP_EN_SET, GRP_EN_CLR:
                    rd_word = mbw ? 32'(en_mb[cpu_sel]) : 32'(en_dev[cpu_sel]);
                default: rd_word = '0;
            endcase
        end
    end

    // Register the read data and its valid flag.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rdata_o  <= '0;
            rvalid_o <= 1'b0;
        end else begin
            rvalid_o <= rd_en_i;
            if (rd_en_i) rdata_o <= rd_word;
        end
    end

    // R11: valid follows a read strobe by one cycle
    a_r11_rvalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_en_i |=> rvalid_o);
    // R11: no valid without a read strobe
    a_r11_no_rvalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> !rvalid_o);
    // R2: identification register returns the line count
    a_r2_id: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && addr_i == '0) |=> (rdata_o == 32'(NUM_DEV)));
    // R6: plain raw writes leave the mailbox state unchanged
    a_r6_raw_plain: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && grp == GRP_RAW) |=> $stable(mb_raw));
endmodule

// File: tb/ipi_irq_ctrl_bench.sv
`timescale 1ns/1ps
module ipi_irq_ctrl_bench;
    localparam int NUM_CPU = 2;
    localparam int NUM_DEV = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NUM_DEV-1:0] dev = '0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rdata;
    logic        rvalid;
    logic [NUM_CPU-1:0] irq;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    ipi_irq_ctrl u_ipi_irq_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .dev_irq_i(dev), .addr_i(addr),
        .wr_en_i(wr_en), .wdata_i(wdata), .rd_en_i(rd_en),
        .rdata_o(rdata), .rvalid_o(rvalid), .irq_o(irq)
    );

    // Monitor: pops one expectation per returned read.
    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R11: unexpected read data %h, expected none", rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s: read got %h, expected %h", t, rdata, e);
                end
            end
        end
    end

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk_irq(input logic [NUM_CPU-1:0] e, input string t);
        #1;
        n_cmp++;
        if (irq !== e) begin
            n_bad++;
            $display("FAIL %s: irq got %b, expected %b", t, irq, e);
        end
    endtask

    initial begin
        fork
            begin
                repeat (4) @(negedge clk);
                rst_n = 1'b1;
                chk_irq(2'b00, "R1 irq after reset");
                n_cmp++;
                if (rvalid !== 1'b0) begin
                    n_bad++;
                    $display("FAIL R1: rvalid got %b, expected 0", rvalid);
                end
                do_read(8'd0,  32'd4, "R2 id register");
                do_read(8'd40, 32'd0, "R1 cpu0 device enable");
                do_read(8'd76, 32'd0, "R1 cpu1 mailbox enable");
                do_read(8'd12, 32'd0, "R1 mailbox raw");
                // Device lines pattern 1010, nothing enabled.
                dev = 4'b1010;
                do_read(8'd8,  32'hA, "R4 raw follows lines");
                do_read(8'd32, 32'h0, "R9 source masked");
                chk_irq(2'b00, "R10 masked lines");
                do_write(8'd8, 32'hF);
                do_read(8'd8,  32'hA, "R6 plain raw write ignored");
                do_write(8'd16, 32'hF);
                do_read(8'd8,  32'hA, "R4 raw-set device write ignored");
                // Enable word of CPU0.
                do_write(8'd40, 32'h3);
                do_read(8'd40, 32'h3, "R7 enable load");
                do_read(8'd48, 32'h3, "R8 set alias readback");
                do_read(8'd56, 32'h3, "R8 clear alias readback");
                do_read(8'd32, 32'h2, "R9 source = raw AND enable");
                chk_irq(2'b01, "R10 cpu0 line");
                do_write(8'd48, 32'h4);
                do_read(8'd40, 32'h7, "R7 set-ones");
                do_write(8'd56, 32'h1);
                do_read(8'd40, 32'h6, "R7 clear-ones");
                do_read(8'd72, 32'h0, "R3 cpu1 enable separate");
                dev = 4'b0000;
                chk_irq(2'b00, "R10 lines fall same cycle");
                do_read(8'd32, 32'h0, "R4 level not latched");
                // Mailboxes.
                do_write(8'd20, 32'h4);
                do_read(8'd12, 32'h4, "R5 raise cpu1 mailbox 0");
                do_read(8'd28, 32'h4, "R8 raw-clear alias readback");
                chk_irq(2'b00, "R10 mailbox not enabled");
                do_write(8'd76, 32'h4);
                do_read(8'd68, 32'h4, "R9 cpu1 mailbox source");
                chk_irq(2'b10, "R10 cpu1 mailbox line");
                do_write(8'd20, 32'h1);
                do_read(8'd12, 32'h5, "R5 zero bits keep state");
                do_write(8'd28, 32'h4);
                do_read(8'd12, 32'h1, "R5 acknowledge one bit");
                chk_irq(2'b00, "R5 line drops after ack");
                do_write(8'd36, 32'hF);
                do_read(8'd36, 32'h0, "R6 source write ignored");
                do_write(8'd12, 32'h0);
                do_read(8'd12, 32'h1, "R6 plain raw mailbox write ignored");
                do_read(8'd92, 32'h4, "R8 cpu1 enable-clear alias");
                do_write(8'd92, 32'h4);
                do_read(8'd76, 32'h0, "R7 cpu1 clear-ones");
                do_read(8'd96, 32'h0, "R3 unmapped high");
                do_read(8'd4,  32'h0, "R3 unmapped low");
                do_write(8'd0, 32'h55);
                do_read(8'd0,  32'd4, "R2 id read-only");
                repeat (3) @(negedge clk);
                if (exp_q.size() != 0) begin
                    n_bad++;
                    $display("FAIL R11: %0d reads unanswered, expected 0", exp_q.size());
                end
            end
            begin
                repeat (20000) @(posedge clk);
                n_bad++;
                $display("FAIL watchdog: run hung, expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule